// File: doc/BRIEF.md
# Coherent Transaction Type Selector

This block sits on the request side of a cached master that takes part in a coherent interconnect. For each request it receives the present state of the line in the local cache and the operation the cache wants to perform. The operation is one of: read miss, full-line store, partial-line store, dirty eviction, clean eviction, or eager clean. From these it chooses the coherent transaction to issue and the channel that carries it. It also reports the state the line is expected to hold once that transaction completes. Operations that need no bus traffic are reported with a "none" opcode.

Two static configuration pins shape the choice:

- The cache-model pin selects the read variant used on a shareable read miss. The three models are any-state, MESI-only and write-through.
- The force pin replaces CleanUnique with ReadUnique. This spends an extra memory read in exchange for a single permission path.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream through one register stage. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. A result is consumed when `rsp_valid` and `rsp_ready` are both high. While a result is stalled, the block holds it unchanged and deasserts `req_ready`.

Top module: `coh_txn_select`

## Requirements
- R1: A read miss (op 0) on an Invalid line (state 0) issues ReadShared (opcode 1) for model 0, ReadNotSharedDirty (opcode 3) for model 1 and ReadClean (opcode 2) for model 2, with post state SharedClean (3). A read op on any valid line issues none (opcode 0) and leaves the state unchanged.
- R2: A full-line store (op 1) to an Invalid line issues MakeUnique (opcode 6), and the post state is UniqueDirty (2).
- R3: A partial-line store (op 2) to an Invalid line issues ReadUnique (opcode 4), and the post state is UniqueDirty.
- R4: A partial-line store to SharedClean (3) or SharedDirty (4) issues CleanUnique (opcode 5), or ReadUnique when `cfg_force_ru` is 1. A full-line store to a shared line issues MakeUnique. In every case the post state is UniqueDirty.
- R5: Any store to UniqueClean (1) or UniqueDirty (2) issues none, and the post state is UniqueDirty.
- R6: WriteBack (7), WriteClean (8) and Evict (9) travel on the write channel (`rsp_write_chan` = 1). Every other opcode, including the write-permission requests, reports the read channel (0).
- R7: An eviction (op 3 dirty, op 4 clean) of a dirty line (UniqueDirty or SharedDirty) issues WriteBack, and of a clean line issues Evict, whatever the op says. The post state is Invalid (0). Evicting an Invalid line issues none.
- R8: An eager clean (op 5) issues WriteClean, taking UniqueDirty to UniqueClean and SharedDirty to SharedClean. On any other state it issues none and leaves the state unchanged.
- R9: A result appears on the output one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the result stays stable and `req_ready` is low.
- R10: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_model | input | 2 | Cache model: 0 any-state, 1 MESI-only, 2 write-through |
| cfg_force_ru | input | 1 | Use ReadUnique in place of CleanUnique |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_state | input | 3 | Local line state (0 I, 1 UC, 2 UD, 3 SC, 4 SD) |
| req_op | input | 3 | Intended operation (0..5 as in the requirements) |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_opcode | output | 4 | Chosen transaction (0 none .. 9 Evict) |
| rsp_write_chan | output | 1 | 1 = write channel, 0 = read channel |
| rsp_next_state | output | 3 | Expected line state after completion |

## Verification
The bench sweeps every pairing of line state, operation, model and force bit, so each corner below is checked.

- A shared line taking a partial store has to pick CleanUnique. A design that fetched data there, or ignored the force bit, would report the wrong opcode.
- An eviction whose op class contradicts the line's dirtiness must follow the line. A design that did not would drop dirty data with Evict or write back a clean line.
- A design that routed write-permission requests to the write channel would report the wrong channel bit.

A stall holds the output while a second request waits. This shows whether a result is overwritten, or the new request is lost, under back-pressure.

// File: rtl/coh_txn_pkg.sv
package coh_txn_pkg;
  localparam int STATE_W = 3;
  localparam int OP_W    = 3;
  localparam int OPC_W   = 4;
  localparam int MODEL_W = 2;

  typedef enum logic [STATE_W-1:0] {
    LS_INV = 3'd0, LS_UC = 3'd1, LS_UD = 3'd2, LS_SC = 3'd3, LS_SD = 3'd4
  } lstate_e;

  typedef enum logic [OP_W-1:0] {
    OP_RD_MISS = 3'd0, OP_ST_FULL = 3'd1, OP_ST_PART = 3'd2,
    OP_EV_DIRTY = 3'd3, OP_EV_CLEAN = 3'd4, OP_EAGER = 3'd5
  } lop_e;

  typedef enum logic [OPC_W-1:0] {
    TX_NONE = 4'd0, TX_RD_SHARED = 4'd1, TX_RD_CLEAN = 4'd2, TX_RD_NSD = 4'd3,
    TX_RD_UNIQUE = 4'd4, TX_CLEAN_UNIQUE = 4'd5, TX_MAKE_UNIQUE = 4'd6,
    TX_WRITE_BACK = 4'd7, TX_WRITE_CLEAN = 4'd8, TX_EVICT = 4'd9
  } txn_e;

  typedef enum logic [MODEL_W-1:0] {
    CM_ANY = 2'd0, CM_MESI = 2'd1, CM_WTHRU = 2'd2
  } cmodel_e;

  typedef struct packed {
    logic [OPC_W-1:0]   opc;
    logic               wr_chan;
    logic [STATE_W-1:0] nxt;
  } sel_res_t;

  function automatic logic st_valid(input logic [STATE_W-1:0] s);
    return (s == LS_UC) || (s == LS_UD) || (s == LS_SC) || (s == LS_SD);
  endfunction

  function automatic logic st_dirty(input logic [STATE_W-1:0] s);
    return (s == LS_UD) || (s == LS_SD);
  endfunction

  function automatic logic st_shared(input logic [STATE_W-1:0] s);
    return (s == LS_SC) || (s == LS_SD);
  endfunction
endpackage

// File: rtl/read_variant_sel.sv
module read_variant_sel
  import coh_txn_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  logic [MODEL_W-1:0] model,
  output sel_res_t           res
);
  always_comb begin
    res.wr_chan = 1'b0;
    if (state == LS_INV) begin
      res.nxt = LS_SC;
      unique case (model)
        CM_MESI:  res.opc = TX_RD_NSD;
        CM_WTHRU: res.opc = TX_RD_CLEAN;
        default:  res.opc = TX_RD_SHARED;
      endcase
    end else begin
      res.opc = TX_NONE;
      res.nxt = state;
    end
  end
endmodule

// File: rtl/store_perm_sel.sv
module store_perm_sel
  import coh_txn_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  logic               full_line,
  input  logic               force_ru,
  output sel_res_t           res
);
  always_comb begin
    res.wr_chan = 1'b0;
    res.nxt     = LS_UD;
    if (state == LS_UC || state == LS_UD) begin
      res.opc = TX_NONE;
    end else if (full_line) begin
      res.opc = TX_MAKE_UNIQUE;
    end else if (st_shared(state) && !force_ru) begin
      res.opc = TX_CLEAN_UNIQUE;
    end else if (st_shared(state) || state == LS_INV) begin
      res.opc = TX_RD_UNIQUE;
    end else begin
      res.opc = TX_NONE;
      res.nxt = state;
    end
  end
endmodule

// File: rtl/line_release_sel.sv
module line_release_sel
  import coh_txn_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  logic               eager,
  output sel_res_t           res
);
  always_comb begin
    res.opc     = TX_NONE;
    res.wr_chan = 1'b0;
    res.nxt     = state;
    if (eager) begin
      if (st_dirty(state)) begin
        res.opc     = TX_WRITE_CLEAN;
        res.wr_chan = 1'b1;
        res.nxt     = (state == LS_SD) ? LS_SC : LS_UC;
      end
    end else if (st_valid(state)) begin
      res.opc     = st_dirty(state) ? TX_WRITE_BACK : TX_EVICT;
      res.wr_chan = 1'b1;
      res.nxt     = LS_INV;
    end
  end
endmodule

// File: rtl/coh_txn_select.sv
module coh_txn_select
  import coh_txn_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODEL_W-1:0] cfg_model,
  input  logic               cfg_force_ru,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [STATE_W-1:0] req_state,
  input  logic [OP_W-1:0]    req_op,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [OPC_W-1:0]   rsp_opcode,
  output logic               rsp_write_chan,
  output logic [STATE_W-1:0] rsp_next_state
);
  sel_res_t rd_res, st_res, rel_res, pick;
  logic     take;

  read_variant_sel u_rd (
    .state(req_state), .model(cfg_model), .res(rd_res)
  );

  store_perm_sel u_st (
    .state(req_state), .full_line(req_op == OP_ST_FULL),
    .force_ru(cfg_force_ru), .res(st_res)
  );

  line_release_sel u_rel (
    .state(req_state), .eager(req_op == OP_EAGER), .res(rel_res)
  );

  always_comb begin
    unique case (req_op)
      OP_RD_MISS:                          pick = rd_res;
      OP_ST_FULL, OP_ST_PART:              pick = st_res;
      OP_EV_DIRTY, OP_EV_CLEAN, OP_EAGER:  pick = rel_res;
      default: begin
        pick.opc     = TX_NONE;
        pick.wr_chan = 1'b0;
        pick.nxt     = req_state;
      end
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_opcode     <= TX_NONE;
      rsp_write_chan <= 1'b0;
      rsp_next_state <= LS_INV;
    end else begin
      if (take) begin
        rsp_valid      <= 1'b1;
        rsp_opcode     <= pick.opc;
        rsp_write_chan <= pick.wr_chan;
        rsp_next_state <= pick.nxt;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_opcode) &&
      $stable(rsp_write_chan) && $stable(rsp_next_state)));

  assert_chan_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_write_chan == (rsp_opcode == TX_WRITE_BACK ||
      rsp_opcode == TX_WRITE_CLEAN || rsp_opcode == TX_EVICT)));

  assert_make_unique_dirty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_opcode == TX_MAKE_UNIQUE) |-> rsp_next_state == LS_UD);

  assert_release_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_opcode == TX_WRITE_BACK || rsp_opcode == TX_EVICT))
      |-> rsp_next_state == LS_INV);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: tb/sim_coh_txn_select.sv
module sim_coh_txn_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_model = 2'd0;
  logic       cfg_force_ru = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_state = 3'd0;
  logic [2:0] req_op = 3'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [3:0] rsp_opcode;
  logic       rsp_write_chan;
  logic [2:0] rsp_next_state;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  coh_txn_select u0 (
    .clk(clk), .rst_n(rst_n), .cfg_model(cfg_model), .cfg_force_ru(cfg_force_ru),
    .req_valid(req_valid), .req_ready(req_ready), .req_state(req_state),
    .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_opcode(rsp_opcode), .rsp_write_chan(rsp_write_chan),
    .rsp_next_state(rsp_next_state)
  );

  // expected result packed as {opcode, chan, next}
  function automatic logic [7:0] model_ref(input int s, input int op, input int m, input int f);
    int opc; int nx;
    bit dirty = (s == 2) || (s == 4);
    bit vld   = (s >= 1) && (s <= 4);
    opc = 0; nx = s;
    if (op == 0) begin            // R1
      if (s == 0) begin
        opc = (m == 1) ? 3 : (m == 2) ? 2 : 1; nx = 3;
      end
    end else if (op == 1 || op == 2) begin
      nx = 2;
      if (s == 1 || s == 2) opc = 0;                 // R5
      else if (op == 1) opc = 6;                     // R2, R4
      else if (s == 0) opc = 4;                      // R3
      else opc = f ? 4 : 5;                          // R4
    end else if (op == 3 || op == 4) begin           // R7
      if (vld) begin opc = dirty ? 7 : 9; nx = 0; end
    end else if (op == 5) begin                      // R8
      if (dirty) begin opc = 8; nx = s - 1; end
    end
    return {opc[3:0], (opc >= 7) ? 1'b1 : 1'b0, nx[2:0]};   // R6
  endfunction

  function automatic string tag_of(input int s, input int op);
    if (op == 0) return "R1";
    if (op == 1 || op == 2) begin
      if (s == 1 || s == 2) return "R5";
      if (s == 0) return (op == 1) ? "R2" : "R3";
      return "R4";
    end
    if (op == 5) return "R8";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got opc=%0d ch=%0d nx=%0d expected opc=%0d ch=%0d nx=%0d",
               tag, got[7:4], got[3], got[2:0], exp[7:4], exp[3], exp[2:0]);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check_bit("R10 rsp_valid", rsp_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R10 rsp_valid", rsp_valid, 1'b0);
    check_bit("R10 req_ready", req_ready, 1'b1);

    // exhaustive sweep
    for (int m = 0; m < 3; m++)
      for (int f = 0; f < 2; f++)
        for (int op = 0; op < 6; op++)
          for (int s = 0; s < 5; s++) begin
            cfg_model = m[1:0]; cfg_force_ru = f[0];
            req_state = s[2:0]; req_op = op[2:0]; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check_bit("R9 valid after accept", rsp_valid, 1'b1);
            check(tag_of(s, op), {rsp_opcode, rsp_write_chan, rsp_next_state},
                  model_ref(s, op, m, f));
          end
    @(negedge clk);
    check_bit("R9 drained", rsp_valid, 1'b0);

    // back-pressure: partial store to SD, then eager clean on UD waits
    cfg_model = 2'd0; cfg_force_ru = 1'b0;
    rsp_ready = 1'b0;
    req_state = 3'd4; req_op = 3'd2; req_valid = 1'b1;
    @(negedge clk);
    req_state = 3'd2; req_op = 3'd5;
    check_bit("R9 ready low when stalled", req_ready, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 held R4", {rsp_opcode, rsp_write_chan, rsp_next_state}, model_ref(4, 2, 0, 0));
    check_bit("R9 still valid", rsp_valid, 1'b1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next R8", {rsp_opcode, rsp_write_chan, rsp_next_state}, model_ref(2, 5, 0, 0));
    @(negedge clk);
    check_bit("R9 empty", rsp_valid, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule